// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital side of a 12-bit serial-input converter. It runs on a fast system clock. It brings the frame select (`sync_n`, active low), the serial clock and the serial data into that clock domain and detects edges of the serial clock there. Frames are 16 bits long and arrive MSB first. Each frame carries a 4-bit control code and a 12-bit data word. The block executes the code. It holds the 12-bit converter code that drives the analog ladder.

The block has two runtime modes. In chained mode, which is the state after reset, several devices share the select and the serial clock. Each device passes its bits on to the next one through `sdo`. One select release then updates every device in the chain at the same time. In stand-alone mode, a frame executes as soon as its sixteenth bit is sampled. The edge that samples data can be moved from falling to rising. `sdo` always changes on the other edge. A readback command makes the next frame shift the converter code out on `sdo`.

The controller has four states:
- IDLE: the select is high.
- ARMED: the select is low and no sampling edge has arrived yet.
- SHIFT: between 1 and 15 bits are held.
- HOLD: 16 bits have been received.

The transitions are:
- select fall: IDLE to ARMED.
- first sampling edge: ARMED to SHIFT.
- sixteenth sampling edge: SHIFT to HOLD.
- early release (abort): SHIFT to IDLE.
- release: HOLD to IDLE, or ARMED to IDLE.

Top module: `sdac_cmd_front`

## Requirements
- R1: After reset the converter code is 0, `sdo` is 0, the frame register is 0, the block is in chained mode and data is sampled on the falling serial clock edge.
- R2: A frame is 16 bits sent MSB first. Bits 15..12 are the control code and bits 11..0 are the data, with bit 11 as the data MSB. Code 0001 copies the data into the converter code.
- R3: In chained mode nothing executes while bits are shifting. The code held in the frame register executes when the select rises, provided that at least 16 sampling edges were seen.
- R4: In stand-alone mode the frame executes on the 16th sampling edge, while the select is still low. Further edges before the select is released do not change the frame register.
- R5: In stand-alone mode, releasing the select after 1 to 15 sampling edges discards the frame and clears the frame register. The converter code and both modes stay as they were.
- R6: Code 1011 sets the converter code to 0. Code 1100 sets it to midscale, 0x800.
- R7: Code 1010 moves data sampling to the rising edge, starting with the next frame. `sdo` then changes on falling edges.
- R8: Code 0010 loads the readback word into the frame register. The readback word is four 0 bits followed by the converter code. During the next frame, `sdo` presents that word MSB first, with one bit before each sampling edge.
- R9: Code 0000 and the reserved codes (0011 to 1000, 1101 to 1111) change neither the converter code nor any mode.
- R10: `sdo` presents bit 15 of the frame register and updates on the edge that does not sample data. In a two-device chain, the first 16 `sdo` bits of a 32-bit frame are the first device's previous register contents, and the next 16 are the first frame sent.
- R11: While the select is high, serial clock and data activity has no effect. A non-sampling edge between the select fall and the first sampling edge is ignored.
- R12: In chained mode, releasing the select after 1 to 15 sampling edges discards the frame and clears the frame register, without executing it.
- R13: Code 1001 switches the block to stand-alone mode. Only a reset returns it to chained mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, for chaining and readback |
| dac_code | output | 12 | Converter code driving the ladder |

## Verification
A two-device chain is driven with 32-bit streams that carry different commands for each device. This separates a device that executes during shifting from one that waits for the select release. The `sdo` stream shows whether the pass-through is delayed by exactly one frame.

Stand-alone frames are checked at three points: right after the 16th edge, after surplus edges, and after an early release. These points show whether the execution moment and the abort clearing are right. The reserved codes, idle activity and a leading non-sampling edge show whether any stray input leaks into state. Readbacks taken before and after the switch to the rising edge show whether the output edge tracks the sampling edge.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HOLD  = 2'd3
    } fe_state_t;

    localparam logic [3:0] CODE_NOP    = 4'b0000;
    localparam logic [3:0] CODE_LOAD   = 4'b0001;
    localparam logic [3:0] CODE_READ   = 4'b0010;
    localparam logic [3:0] CODE_SOLO   = 4'b1001;
    localparam logic [3:0] CODE_RISE   = 4'b1010;
    localparam logic [3:0] CODE_ZERO   = 4'b1011;
    localparam logic [3:0] CODE_MID    = 4'b1100;

    typedef struct packed {
        logic load;
        logic zero;
        logic mid;
        logic readback;
        logic go_solo;
        logic go_rise;
    } act_t;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int              N       = 3,
    parameter int              STAGES  = 2,
    parameter logic [N-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[b]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], din[b]};
            end
        end
        assign dout[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/sdac_decode.sv
module sdac_decode
    import sdac_pkg::*;
(
    input  logic [3:0] code,
    output act_t       act
);

    always_comb begin
        act = '0;
        unique case (code)
            CODE_LOAD: act.load     = 1'b1;
            CODE_READ: act.readback = 1'b1;
            CODE_SOLO: act.go_solo  = 1'b1;
            CODE_RISE: act.go_rise  = 1'b1;
            CODE_ZERO: act.zero     = 1'b1;
            CODE_MID:  act.mid      = 1'b1;
            default:   act          = '0;
        endcase
    end

endmodule

// File: rtl/sdac_dacreg.sv
module sdac_dacreg
    import sdac_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CODE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  act_t                     act,
    input  logic [DATA_W-1:0]        din,
    output logic [DATA_W-1:0]        dac_q,
    output logic [DATA_W+CODE_W-1:0] rb_word
);

    localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_q <= '0;
        end else if (en) begin
            if (act.load) begin
                dac_q <= din;
            end else if (act.zero) begin
                dac_q <= '0;
            end else if (act.mid) begin
                dac_q <= MIDSCALE;
            end
        end
    end

    assign rb_word = {{CODE_W{1'b0}}, dac_q};

endmodule

// File: rtl/sdac_cmd_front.sv
module sdac_cmd_front
    import sdac_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int CODE_W    = 4,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic              sdo,
    output logic [DATA_W-1:0] dac_code
);

    localparam int FRAME_W = DATA_W + CODE_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int MSB     = FRAME_W - 1;

    // synchronized pins: [2]=select, [1]=serial clock, [0]=data
    logic [2:0] pins_s;
    logic       sync_s, sclk_s, sdin_s, sclk_d;

    sdac_sync #(
        .N(3), .STAGES(SYNC_STGS), .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({sync_n, sclk, sdin}),
        .dout(pins_s)
    );

    assign sync_s = pins_s[2];
    assign sclk_s = pins_s[1];
    assign sdin_s = pins_s[0];

    fe_state_t            st_q, st_d;
    logic [FRAME_W-1:0]   shreg;
    logic [CNT_W-1:0]     cnt_q;
    logic                 sdo_q, chain_q, rise_q;

    logic sclk_r, sclk_f, act_edge, inact_edge, sync_lo;
    logic last_edge, exec_go;
    logic [FRAME_W-1:0]   shift_nx, exec_word;
    logic [FRAME_W-1:0]   rb_word;
    act_t                 act;

    assign sclk_r     = sclk_s & ~sclk_d;
    assign sclk_f     = ~sclk_s & sclk_d;
    assign act_edge   = rise_q ? sclk_r : sclk_f;
    assign inact_edge = rise_q ? sclk_f : sclk_r;
    assign sync_lo    = ~sync_s;
    assign shift_nx   = {shreg[MSB-1:0], sdin_s};

    assign last_edge = (st_q == ST_SHIFT) && sync_lo && act_edge
                       && (cnt_q == CNT_W'(FRAME_W - 1));
    assign exec_go   = chain_q ? ((st_q == ST_HOLD) && sync_s)
                               : last_edge;
    assign exec_word = chain_q ? shreg : shift_nx;

    sdac_decode u_dec (
        .code(exec_word[MSB -: CODE_W]),
        .act(act)
    );

    sdac_dacreg #(
        .DATA_W(DATA_W), .CODE_W(CODE_W)
    ) u_dac (
        .clk(clk), .rst_n(rst_n),
        .en(exec_go), .act(act),
        .din(exec_word[DATA_W-1:0]),
        .dac_q(dac_code),
        .rb_word(rb_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (sync_lo) st_d = ST_ARMED;
            ST_ARMED: begin
                if (sync_s)        st_d = ST_IDLE;
                else if (act_edge) st_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (sync_s)         st_d = ST_IDLE;
                else if (last_edge) st_d = ST_HOLD;
            end
            ST_HOLD:  if (sync_s) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            cnt_q   <= '0;
            sdo_q   <= 1'b0;
            chain_q <= 1'b1;
            rise_q  <= 1'b0;
            sclk_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            unique case (st_q)
                ST_IDLE: begin
                    sdo_q <= shreg[MSB];
                    cnt_q <= '0;
                end
                ST_ARMED: begin
                    sdo_q <= shreg[MSB];
                    if (sync_lo && act_edge) begin
                        shreg <= shift_nx;
                        cnt_q <= CNT_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (sync_s) begin
                        shreg <= '0;
                        cnt_q <= '0;
                    end else begin
                        if (act_edge) begin
                            shreg <= shift_nx;
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                        if (inact_edge) sdo_q <= shreg[MSB];
                    end
                end
                ST_HOLD: begin
                    if (sync_s) begin
                        cnt_q <= '0;
                    end else begin
                        if (chain_q && act_edge) shreg <= shift_nx;
                        if (inact_edge) sdo_q <= shreg[MSB];
                    end
                end
                default: ;
            endcase
            if (exec_go && act.readback) shreg   <= rb_word;
            if (exec_go && act.go_solo)  chain_q <= 1'b0;
            if (exec_go && act.go_rise)  rise_q  <= 1'b1;
        end
    end

    assign sdo = sdo_q;

endmodule

// File: rtl/sdac_cmd_front_chk.sv
module sdac_cmd_front_chk
    import sdac_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int FRAME_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sync_s,
    input logic               inact_edge,
    input fe_state_t          st_q,
    input logic               chain_q,
    input logic               rise_q,
    input logic [FRAME_W-1:0] shreg,
    input logic               sdo,
    input logic [DATA_W-1:0]  dac_code
);

    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (dac_code == '0 && !sdo && chain_q && !rise_q && shreg == '0));

    a_r3_chain_no_exec_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chain_q) && !$past(sync_s)) |-> $stable(dac_code));

    a_r4_solo_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_q && st_q == ST_HOLD) |=> $stable(shreg));

    a_r5_abort_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHIFT && sync_s) |=>
            ($stable(dac_code) && $stable(chain_q) && $stable(rise_q) && shreg == '0));

    a_r10_sdo_on_other_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SHIFT || st_q == ST_HOLD) && !inact_edge) |=> $stable(sdo));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && sync_s) |=> ($stable(shreg) && $stable(dac_code)));

    a_r13_chain_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(chain_q) |-> !chain_q);

endmodule

bind sdac_cmd_front sdac_cmd_front_chk #(
    .DATA_W(DATA_W), .FRAME_W(FRAME_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sync_s(sync_s), .inact_edge(inact_edge),
    .st_q(st_q), .chain_q(chain_q), .rise_q(rise_q), .shreg(shreg),
    .sdo(sdo), .dac_code(dac_code)
);

// File: tb/sim_sdac_cmd_front.sv
`timescale 1ns/1ps
module sim_sdac_cmd_front;

    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_n = 1'b1;
    logic sclk = 1'b1;
    logic sdin = 1'b0;
    logic sdo0, sdo1;
    logic [11:0] dac0, dac1;
    logic rise_mode = 1'b0;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sdac_cmd_front u0 (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk),
        .sdin(sdin), .sdo(sdo0), .dac_code(dac0)
    );

    sdac_cmd_front u1 (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk),
        .sdin(sdo0), .sdo(sdo1), .dac_code(dac1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic so);
        sdin = b;
        wclk(HALF);
        so = sdo0;
        sclk = rise_mode;
        wclk(HALF);
        sclk = ~rise_mode;
    endtask

    task automatic shift_bits(input logic [31:0] w, input int n, output logic [31:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            logic so;
            clk_bit(w[n-1-i], so);
            got[n-1-i] = so;
        end
    endtask

    task automatic sel();
        sync_n = 1'b0;
        wclk(HALF);
    endtask

    task automatic rel();
        wclk(HALF);
        sync_n = 1'b1;
        wclk(2*HALF + 4);
    endtask

    task automatic frame(input logic [31:0] w, input int n, output logic [31:0] got);
        sel();
        shift_bits(w, n, got);
        rel();
    endtask

    task automatic t_reset();
        chk("R1 dac0", dac0, 0);
        chk("R1 sdo0", sdo0, 0);
        chk("R1 dac1", dac1, 0);
    endtask

    task automatic t_chain();
        logic [31:0] g;
        // first 16 bits go to u1, last 16 to u0
        sel();
        shift_bits({16'h1123, 16'h1ABC}, 32, g);
        chk("R3 no exec before release u0", dac0, 0);
        chk("R3 no exec before release u1", dac1, 0);
        chk("R10 passthrough old", g[31:16], 0);
        chk("R10 passthrough delayed", g[15:0], 16'h1123);
        rel();
        chk("R2 R3 u0 loaded", dac0, 12'hABC);
        chk("R3 u1 loaded", dac1, 12'h123);
        // readback on u0, nop on u1
        frame({16'h0777, 16'h2555}, 32, g);
        chk("R9 nop u1", dac1, 12'h123);
        chk("R8 readback no change", dac0, 12'hABC);
        frame({16'hB000, 16'h0999}, 32, g);
        chk("R8 chain readback word", g[31:16], 16'h0ABC);
        chk("R6 zero u1", dac1, 0);
        chk("R9 nop u0", dac0, 12'hABC);
    endtask

    task automatic t_chain_short();
        logic [31:0] g;
        frame(32'h0000_0011, 8, g);
        chk("R12 short dac0", dac0, 12'hABC);
        frame({16'hC000, 16'h9000}, 32, g);
        chk("R12 register cleared", g[31:16], 0);
        chk("R6 midscale u1", dac1, 12'h800);
    endtask

    task automatic t_solo();
        logic [31:0] g;
        sel();
        shift_bits(32'h15A5, 16, g);
        chk("R4 exec on 16th edge", dac0, 12'h5A5);
        chk("R13 solo readback of prior", g[15:0], 16'h9000);
        shift_bits(32'hF, 4, g);
        rel();
        chk("R4 after surplus edges", dac0, 12'h5A5);
        // abort after 10 edges; its sdo shows top of 0x15A5 if surplus ignored
        frame(32'h3FF, 10, g);
        chk("R4 surplus did not shift", g[9:0], 10'h056);
        chk("R5 abort dac", dac0, 12'h5A5);
        frame(32'h3111, 16, g);
        chk("R5 abort cleared register", g[15:0], 0);
        frame(32'hF222, 16, g);
        chk("R10 solo sdo prior frame", g[15:0], 16'h3111);
        frame(32'h8333, 16, g);
        frame(32'hD444, 16, g);
        chk("R9 reserved no effect", dac0, 12'h5A5);
    endtask

    task automatic t_idle_and_lead();
        logic [31:0] g;
        for (int i = 0; i < 20; i++) begin
            sdin = i[0];
            sclk = ~sclk;
            wclk(HALF);
        end
        chk("R11 idle activity", dac0, 12'h5A5);
        sclk = 1'b0;
        wclk(HALF);
        sync_n = 1'b0;
        wclk(HALF);
        sdin = 1'b1;
        sclk = 1'b1;
        shift_bits(32'h13C3, 16, g);
        rel();
        chk("R11 leading edge ignored", dac0, 12'h3C3);
        frame(32'h2000, 16, g);
        frame(32'h0000, 16, g);
        chk("R8 solo readback word", g[15:0], 16'h03C3);
    endtask

    task automatic t_rise();
        logic [31:0] g;
        frame(32'hA000, 16, g);
        rise_mode = 1'b1;
        sclk = 1'b0;
        wclk(2*HALF);
        frame(32'h10F0, 16, g);
        chk("R7 rising load", dac0, 12'h0F0);
        chk("R7 sdo on falling", g[15:0], 16'hA000);
        frame(32'hC000, 16, g);
        chk("R6 midscale", dac0, 12'h800);
        frame(32'h2000, 16, g);
        frame(32'hB000, 16, g);
        chk("R8 R7 readback rising", g[15:0], 16'h0800);
        chk("R6 zero", dac0, 0);
    endtask

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        t_reset();
        t_chain();
        t_chain_short();
        t_solo();
        t_idle_and_lead();
        t_rise();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule